// File: doc/BRIEF.md
# Overflow-Extended Real-Time Counter with Compare Channels

This block is a free-running low-frequency timer. A narrow hardware counter advances on a single-cycle tick enable that arrives in the system clock domain, normally at 32.768 kHz. A wrap counter records every time the narrow count passes all ones, and the two are joined into a wide tick timebase. The wrap counter and the narrow count change on the same clock edge, so the wide value is always coherent and never needs a re-read loop.

Several compare channels share the counter. Each holds a compare value as wide as the narrow counter, a sticky event flag, an event gate and an interrupt gate. A channel raises its event only when the counter steps onto the compare value. Software never writes a compare register directly. It hands a wide tick target to a scheduling port. The scheduler moves any target that is not at least two ticks ahead of the present wide count forward to exactly two ticks ahead, and then stores only the low bits of the result.

Typical use: keep the event gate of a channel open, schedule a wake-up tick, take the interrupt, clear the event flag, then schedule the next target.

Top module: `rtc_ext_timer`

## Requirements
- R1: After reset the narrow count, the wrap count, the wide timebase, every compare value and every event flag read zero, and no interrupt is asserted.
- R2: With the default prescaler setting, the narrow count rises by exactly one for each cycle in which `tick_i` is high and holds in every other cycle.
- R3: When the narrow count is all ones and it advances, it becomes zero, the wrap count rises by one, and `ovf_pulse_o` is high for exactly the one cycle after that edge. The wrap indication needs no enable.
- R4: `ext_ticks_o` is always the wrap count placed above the narrow count. Each advance, including a wrap, raises it by exactly one in the same cycle.
- R5: When the counter steps from N-1 to N and a channel's compare value is N, that channel's event flag is set on that edge, provided its event gate is high.
- R6: A compare value equal to the present count does not raise an event. An event follows only from a later step onto that value.
- R7: A schedule request loads the channel's compare value with the low bits of the target. If the target minus (present wide count + 2), taken as a signed number, is zero or negative, the low bits of present wide count + 2 are loaded instead.
- R8: An event flag stays set until its clear pulse. If a new event and a clear arrive in the same cycle, the flag stays set.
- R9: With its event gate low, a channel's event flag is not set by a compare match.
- R10: A channel's interrupt output is high exactly while both its event flag and its interrupt gate are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle low-frequency tick enable |
| sched_valid_i | input | 1 | Schedule request strobe |
| sched_ch_i | input | CH_W | Channel that the request targets |
| sched_target_i | input | EXT_W | Requested wide tick target |
| evt_en_i | input | NUM_CH | Per-channel event gate |
| irq_en_i | input | NUM_CH | Per-channel interrupt gate |
| evt_clr_i | input | NUM_CH | Per-channel event clear pulse |
| cnt_o | output | CNT_W | Live narrow count |
| ext_ticks_o | output | EXT_W | Wide tick timebase |
| ovf_pulse_o | output | 1 | One-cycle wrap indication |
| cmp_o | output | NUM_CH*CNT_W | Compare values, channel 0 in the low bits |
| evt_o | output | NUM_CH | Sticky event flags |
| irq_o | output | NUM_CH | Gated interrupt requests |

## Verification
The assertions assume that `tick_i` is a clean single-cycle strobe and that `sched_ch_i` names an existing channel whenever `sched_valid_i` is high. They also assume that the event gate does not change in the same cycle as the match that it governs. The bench drives the tick one cycle at a time and only schedules valid channel numbers. It changes gates only in cycles with no tick. It builds the design with a narrow 8-bit counter, so that wraps, lower-bit aliasing of targets and clamping near the wrap can all be reached in a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned RTC_CNT_W    = 24;
  localparam int unsigned RTC_EXT_W    = 32;
  localparam int unsigned RTC_NUM_CH   = 3;
  localparam int unsigned RTC_MIN_LEAD = 2;
  localparam int unsigned RTC_PSC_DIV  = 1;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned OVF_W   = 8,
  parameter int unsigned PSC_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             adv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_W-1:0] ovf_cnt_o,
  output logic             ovf_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic adv;
  logic wrap;

  generate
    if (PSC_DIV <= 1) begin : g_no_psc
      assign adv = tick_i;
    end else begin : g_psc
      localparam int unsigned PSC_W = $clog2(PSC_DIV);
      localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PSC_DIV - 1);
      logic [PSC_W-1:0] psc_q;
      assign adv = tick_i && (psc_q == PSC_LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     psc_q <= '0;
        else if (adv)    psc_q <= '0;
        else if (tick_i) psc_q <= psc_q + 1'b1;
      end
    end
  endgenerate

  assign wrap = adv && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      ovf_cnt_o   <= '0;
      ovf_pulse_o <= 1'b0;
    end else begin
      ovf_pulse_o <= wrap;
      if (adv) cnt_o <= cnt_o + 1'b1;
      // wrap count moves on the same edge so the wide value stays coherent
      if (wrap) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end

  assign adv_o = adv;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && (cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1) && $stable(ovf_cnt_o));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(cnt_o) && $stable(ovf_cnt_o));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && (cnt_o == CNT_MAX) |=> (cnt_o == '0) && (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1) && ovf_pulse_o);
  p_pulse_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |=> !ovf_pulse_o);
endmodule

// File: rtl/rtc_sched_clamp.sv
module rtc_sched_clamp #(
  parameter int unsigned EXT_W    = 32,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned MIN_LEAD = 2
) (
  input  logic [EXT_W-1:0] now_i,
  input  logic [EXT_W-1:0] target_i,
  output logic [CNT_W-1:0] cmp_val_o
);
  logic [EXT_W-1:0] safe;
  logic [EXT_W-1:0] diff;
  logic [EXT_W-1:0] sel;
  logic             late;

  always_comb begin
    safe = now_i + EXT_W'(MIN_LEAD);
    diff = target_i - safe;
    // signed distance copes with wide-count wrap
    late = $signed(diff) <= 0;
    sel  = late ? safe : target_i;
    cmp_val_o = sel[CNT_W-1:0];
  end

  // R7: chosen target never lies behind the safe point
  always_comb begin
    a_lead_r7: assert ($signed(sel - safe) >= 0);
  end
endmodule

// File: rtl/rtc_cmp_chan.sv
module rtc_cmp_chan #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             evt_en_i,
  input  logic             irq_en_i,
  input  logic             evt_clr_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             evt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  assign cnt_nxt = cnt_i + 1'b1;
  // only the step onto the value counts, not a static equality
  assign hit = adv_i && (cnt_nxt == cmp_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o <= '0;
      evt_o <= 1'b0;
    end else begin
      if (load_i) cmp_o <= load_val_i;
      if (hit && evt_en_i) evt_o <= 1'b1;
      else if (evt_clr_i)  evt_o <= 1'b0;
    end
  end

  assign irq_o = evt_o && irq_en_i;

  p_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (cnt_i + 1'b1 == cmp_o) && evt_en_i |=> evt_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && !evt_clr_i |=> evt_o);
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_en_i && !evt_o |=> !evt_o);
  p_static_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !evt_o |=> !evt_o);
  p_cmp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cmp_o));
endmodule

// File: rtl/rtc_ext_timer.sv
module rtc_ext_timer
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W    = RTC_CNT_W,
  parameter int unsigned EXT_W    = RTC_EXT_W,
  parameter int unsigned NUM_CH   = RTC_NUM_CH,
  parameter int unsigned MIN_LEAD = RTC_MIN_LEAD,
  parameter int unsigned PSC_DIV  = RTC_PSC_DIV,
  localparam int unsigned OVF_W   = EXT_W - CNT_W,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    sched_valid_i,
  input  logic [CH_W-1:0]         sched_ch_i,
  input  logic [EXT_W-1:0]        sched_target_i,
  input  logic [NUM_CH-1:0]       evt_en_i,
  input  logic [NUM_CH-1:0]       irq_en_i,
  input  logic [NUM_CH-1:0]       evt_clr_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [EXT_W-1:0]        ext_ticks_o,
  output logic                    ovf_pulse_o,
  output logic [NUM_CH*CNT_W-1:0] cmp_o,
  output logic [NUM_CH-1:0]       evt_o,
  output logic [NUM_CH-1:0]       irq_o
);
  logic             adv;
  logic [OVF_W-1:0] ovf_cnt;
  logic [CNT_W-1:0] load_val;

  rtc_tick_counter #(
    .CNT_W  (CNT_W),
    .OVF_W  (OVF_W),
    .PSC_DIV(PSC_DIV)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .adv_o      (adv),
    .cnt_o      (cnt_o),
    .ovf_cnt_o  (ovf_cnt),
    .ovf_pulse_o(ovf_pulse_o)
  );

  assign ext_ticks_o = {ovf_cnt, cnt_o};

  rtc_sched_clamp #(
    .EXT_W   (EXT_W),
    .CNT_W   (CNT_W),
    .MIN_LEAD(MIN_LEAD)
  ) i_clamp (
    .now_i    (ext_ticks_o),
    .target_i (sched_target_i),
    .cmp_val_o(load_val)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic load;
      assign load = sched_valid_i && (sched_ch_i == CH_W'(c));
      rtc_cmp_chan #(.CNT_W(CNT_W)) i_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .adv_i     (adv),
        .cnt_i     (cnt_o),
        .load_i    (load),
        .load_val_i(load_val),
        .evt_en_i  (evt_en_i[c]),
        .irq_en_i  (irq_en_i[c]),
        .evt_clr_i (evt_clr_i[c]),
        .cmp_o     (cmp_o[c*CNT_W +: CNT_W]),
        .evt_o     (evt_o[c]),
        .irq_o     (irq_o[c])
      );
    end
  endgenerate

  p_ext_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> ext_ticks_o == $past(ext_ticks_o) + 1'b1);
  p_irq_needs_evt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~evt_o) == '0);
endmodule

// File: tb/test_rtc_ext_timer.sv
module test_rtc_ext_timer;
  localparam int CW = 8;
  localparam int EW = 16;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic sched_valid = 1'b0;
  logic [1:0] sched_ch = '0;
  logic [EW-1:0] sched_target = '0;
  logic [NC-1:0] evt_en = '0, irq_en = '0, evt_clr = '0;
  logic [CW-1:0] cnt;
  logic [EW-1:0] ext;
  logic ovf_pulse;
  logic [NC*CW-1:0] cmp;
  logic [NC-1:0] evt, irq;

  int checks = 0;
  int errors = 0;
  int exp_ext = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_ext_timer #(.CNT_W(CW), .EXT_W(EW), .NUM_CH(NC)) i_rtc_ext_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .sched_valid_i(sched_valid), .sched_ch_i(sched_ch), .sched_target_i(sched_target),
    .evt_en_i(evt_en), .irq_en_i(irq_en), .evt_clr_i(evt_clr),
    .cnt_o(cnt), .ext_ticks_o(ext), .ovf_pulse_o(ovf_pulse),
    .cmp_o(cmp), .evt_o(evt), .irq_o(irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      exp_ext = (exp_ext + 1) & 16'hffff;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sched(int ch, int target);
    sched_valid = 1'b1;
    sched_ch = 2'(ch);
    sched_target = EW'(target);
    @(negedge clk);
    sched_valid = 1'b0;
  endtask

  task automatic clear(int ch);
    evt_clr[ch] = 1'b1;
    @(negedge clk);
    evt_clr[ch] = 1'b0;
  endtask

  function automatic int cmp_of(int ch);
    return int'(cmp[ch*CW +: CW]);
  endfunction

  task automatic t_reset();
    check("R1 cnt", int'(cnt), 0);
    check("R1 ext", int'(ext), 0);
    check("R1 evt", int'(evt), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 cmp", int'(cmp), 0);
  endtask

  task automatic t_count();
    idle(5);
    check("R2 hold without tick", int'(ext), 0);
    do_ticks(10);
    check("R2 ten ticks", int'(ext), exp_ext);
    idle(3);
    check("R2 hold after ticks", int'(cnt), exp_ext & 8'hff);
  endtask

  task automatic t_compare();
    evt_en[0] = 1'b1;
    irq_en[0] = 1'b1;
    sched(0, exp_ext + 5);
    check("R7 future target kept", cmp_of(0), (exp_ext + 5) & 8'hff);
    do_ticks(4);
    check("R5 no event before match", int'(evt[0]), 0);
    do_ticks(1);
    check("R5 event on step", int'(evt[0]), 1);
    check("R10 irq gated on", int'(irq[0]), 1);
    irq_en[0] = 1'b0;
    @(negedge clk);
    check("R10 irq gated off", int'(irq[0]), 0);
    do_ticks(3);
    check("R8 flag sticky", int'(evt[0]), 1);
    clear(0);
    check("R8 flag cleared", int'(evt[0]), 0);
  endtask

  task automatic t_clamp();
    sched(0, exp_ext - 100);
    check("R7 past target clamped", cmp_of(0), (exp_ext + 2) & 8'hff);
    sched(0, exp_ext + 2);
    check("R7 zero distance", cmp_of(0), (exp_ext + 2) & 8'hff);
    sched(0, exp_ext + 3);
    check("R7 three ahead kept", cmp_of(0), (exp_ext + 3) & 8'hff);
    sched(0, exp_ext);
    do_ticks(1);
    check("R5 clamped no early event", int'(evt[0]), 0);
    do_ticks(1);
    check("R5 clamped event fires", int'(evt[0]), 1);
    clear(0);
  endtask

  task automatic t_gate();
    evt_en[1] = 1'b0;
    irq_en[1] = 1'b1;
    sched(1, exp_ext + 1);
    check("R7 one ahead clamped", cmp_of(1), (exp_ext + 2) & 8'hff);
    do_ticks(3);
    check("R9 gated off no event", int'(evt[1]), 0);
    check("R10 no irq without event", int'(irq[1]), 0);
  endtask

  task automatic t_wrap();
    do_ticks(255 - exp_ext);
    check("R4 before wrap", int'(ext), 255);
    do_ticks(1);
    check("R3 cnt wraps", int'(cnt), 0);
    check("R4 ext after wrap", int'(ext), 256);
    check("R3 pulse", int'(ovf_pulse), 1);
    @(negedge clk);
    check("R3 pulse one cycle", int'(ovf_pulse), 0);
    do_ticks(7);
    check("R4 ext after wrap plus", int'(ext), exp_ext);
  endtask

  task automatic t_same_count();
    evt_en[2] = 1'b1;
    clear(2);
    sched(2, exp_ext + 256);
    check("R6 cmp equals count", cmp_of(2), int'(cnt));
    idle(2);
    do_ticks(3);
    check("R6 no event from equality", int'(evt[2]), 0);
  endtask

  task automatic t_set_beats_clear();
    evt_en[0] = 1'b1;
    clear(0);
    sched(0, exp_ext + 2);
    do_ticks(1);
    tick = 1'b1;
    evt_clr[0] = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    evt_clr[0] = 1'b0;
    exp_ext = (exp_ext + 1) & 16'hffff;
    check("R8 set wins over clear", int'(evt[0]), 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_compare();
    t_clamp();
    t_gate();
    t_wrap();
    t_same_count();
    t_set_beats_clear();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule